// File: doc/BRIEF.md
# Flushable Instruction Prefetch Buffer

This block sits between an instruction-execution engine and the memory system. It keeps a window of eight consecutive instruction dwords ahead of the engine. Fetches that land inside the window return from local storage, so they put no traffic on the memory side. A fetch outside the window, or one after the window was invalidated, loads a fresh window that starts at the requested dword address. The window is loaded by one or more burst reads. Each entry becomes usable as soon as its beat arrives.

The burst length comes from a configured maximum burst value. It is the largest power of two that does not exceed that value or the window size. If the configured value is below the minimum burst, or the enable input is low, the buffer turns itself off. Each engine fetch then becomes a single-dword read. The engine reports instructions that can rewrite code. A store, or a memory-move without its no-flush option, invalidates the whole window in the same cycle. A burst already accepted by memory still runs to completion, but its beats are dropped.

All addresses on both ports are dword addresses.

Top module: `code_prefetch`

## Requirements
- R1: After reset, `eng_req_ready` is 1 and both `eng_rsp_valid` and `mem_req_valid` are 0.
- R2: With `cfg_enable` low, each engine fetch issues exactly one memory read of length 1 at the fetch address, and the returned dword is passed back on `eng_rsp_data`.
- R3: With `cfg_enable` high but `cfg_max_burst` below 4, the block behaves exactly as in R2.
- R4: With the buffer active, every burst length is the largest power of two not above min(`cfg_max_burst`, 8). A value of 4 to 7 gives two bursts of 4 per window. A value of 8 or more gives one burst of 8. No memory request other than a bypass read has a length below 4.
- R5: A fetch that misses loads a window of 8 dwords. The first burst starts at the requested address and later bursts follow at consecutive addresses. The fetch is answered with the dword at its address once that dword has arrived.
- R6: A fetch whose address is within [base, base+8) of a loaded window returns the buffered dword and issues no memory request.
- R7: Every memory request carries command code 0 (plain read) on `mem_req_cmd`. Codes 1, 2 and 3 (line read, multiple read, write-and-invalidate) are never issued.
- R8: An event with `op_kind` = 1 (memory-move) and `op_noflush` = 0 invalidates the window. The next fetch to a previously buffered address reads memory again.
- R9: A memory-move event with `op_noflush` = 1, or an event with `op_kind` = 0 (other instruction), leaves the window intact. A later fetch inside it issues no memory request.
- R10: An event with `op_kind` = 2 (store) invalidates the window in the same way as R8.
- R11: If the window is invalidated while a burst is in flight, that burst completes and its beats are discarded. The pending fetch is answered from a new window read after the invalidation.
- R12: A fetch outside the current window starts a new window at the fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Turns the prefetch buffer on |
| cfg_max_burst | input | CFG_W | Largest burst, in dwords, the memory side allows |
| eng_req_valid | input | 1 | Engine fetch request |
| eng_req_ready | output | 1 | Block can accept a fetch |
| eng_req_addr | input | ADDR_W | Dword address of the fetch |
| eng_rsp_valid | output | 1 | One-cycle pulse with the fetched dword |
| eng_rsp_data | output | DATA_W | Fetched dword |
| op_valid | input | 1 | Executed-instruction event strobe |
| op_kind | input | 2 | 0 other, 1 memory-move, 2 store |
| op_noflush | input | 1 | No-flush option of a memory-move |
| mem_req_valid | output | 1 | Burst read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | First dword address of the burst |
| mem_req_len | output | LEN_W | Burst length in dwords |
| mem_req_cmd | output | 2 | Read command code |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | DATA_W | Read data |

## Verification
The bench uses the default parameters: an 8-dword window, a minimum burst of 4 and a 5-bit burst setting. A 5-bit setting can take the values 2 and 3, which are below the minimum; 4 and 6, which give two bursts of 4; and 8 and 16, where 16 is capped to a single 8-dword burst. The memory model tags every read with a generation number and changes it after each invalidation. This makes any data served from a stale window, or any discarded beat that was not dropped, show up as a data mismatch.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [1:0] {
    OP_OTHER = 2'd0,
    OP_MOVE  = 2'd1,
    OP_STORE = 2'd2
  } op_kind_e;

  typedef enum logic [1:0] {
    RD_PLAIN  = 2'd0,
    RD_LINE   = 2'd1,
    RD_MULTI  = 2'd2,
    WR_INVAL  = 2'd3
  } mem_cmd_e;

  typedef enum logic [1:0] {
    ES_IDLE,
    ES_LOOK,
    ES_BYP_REQ,
    ES_BYP_WAIT
  } eng_state_e;
endpackage

// File: rtl/pfb_burst_sizer.sv
module pfb_burst_sizer #(
  parameter int LINE_DW   = 8,
  parameter int MIN_BURST = 4,
  parameter int CFG_W     = 5,
  parameter int LEN_W     = 4
) (
  input  logic             cfg_enable,
  input  logic [CFG_W-1:0] cfg_max_burst,
  output logic             pf_en,
  output logic [LEN_W-1:0] burst_len
);
  int unsigned cap;
  int unsigned pw;

  always_comb begin
    cap = 32'(cfg_max_burst);
    if (cap > LINE_DW) cap = LINE_DW;
    pw = 1;
    for (int i = 0; i < LEN_W; i++) begin
      if ((pw << 1) <= cap) pw = pw << 1;
    end
    burst_len = LEN_W'(pw);
    pf_en = cfg_enable && (32'(cfg_max_burst) >= MIN_BURST);
  end
endmodule

// File: rtl/pfb_op_filter.sv
module pfb_op_filter
  import pfb_pkg::*;
(
  input  logic       op_valid,
  input  logic [1:0] op_kind,
  input  logic       op_noflush,
  output logic       flush
);
  op_kind_e kind;

  always_comb begin
    kind  = op_kind_e'(op_kind);
    flush = op_valid && ((kind == OP_STORE) || ((kind == OP_MOVE) && !op_noflush));
  end
endmodule

// File: rtl/pfb_line_store.sv
module pfb_line_store #(
  parameter int LINE_DW = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [LINE_DW-1:0] valid_vec
);
  logic [DATA_W-1:0] mem_q [LINE_DW];

  // data array: no reset so it maps to distributed/block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];

  // clear has priority over a beat landing in the same cycle
  always_ff @(posedge clk) begin
    if (rst || clr) valid_vec <= '0;
    else if (wr_en) valid_vec[wr_idx] <= 1'b1;
  end
endmodule

// File: rtl/code_prefetch.sv
module code_prefetch
  import pfb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LINE_DW   = 8,
  parameter int MIN_BURST = 4,
  parameter int CFG_W     = 5,
  localparam int IDX_W    = $clog2(LINE_DW),
  localparam int LEN_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic [CFG_W-1:0]  cfg_max_burst,
  input  logic              eng_req_valid,
  output logic              eng_req_ready,
  input  logic [ADDR_W-1:0] eng_req_addr,
  output logic              eng_rsp_valid,
  output logic [DATA_W-1:0] eng_rsp_data,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic              op_noflush,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LEN_W-1:0]  mem_req_len,
  output logic [1:0]        mem_req_cmd,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam logic [LEN_W-1:0] LINE_LEN = LEN_W'(LINE_DW);
  localparam logic [LEN_W-1:0] ONE_LEN  = LEN_W'(1);

  // configuration and event decode
  logic             pf_en;
  logic [LEN_W-1:0] burst_len;
  logic             flush;

  pfb_burst_sizer #(
    .LINE_DW(LINE_DW), .MIN_BURST(MIN_BURST), .CFG_W(CFG_W), .LEN_W(LEN_W)
  ) u_sizer (
    .cfg_enable(cfg_enable), .cfg_max_burst(cfg_max_burst),
    .pf_en(pf_en), .burst_len(burst_len)
  );

  pfb_op_filter u_filter (
    .op_valid(op_valid), .op_kind(op_kind), .op_noflush(op_noflush), .flush(flush)
  );

  // state
  eng_state_e        est_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [ADDR_W-1:0] base_q;
  logic              fill_on_q;
  logic [LEN_W-1:0]  issued_q;
  logic [LEN_W-1:0]  recv_q;
  logic [LEN_W-1:0]  fill_bs_q;
  logic              bursting_q;
  logic [LEN_W-1:0]  beats_q;
  logic              discard_q;

  // line storage
  logic               kill;
  logic               wr_en;
  logic [IDX_W-1:0]   off_idx;
  logic [DATA_W-1:0]  rd_data;
  logic [LINE_DW-1:0] valid_vec;

  pfb_line_store #(
    .LINE_DW(LINE_DW), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst(rst), .clr(kill),
    .wr_en(wr_en), .wr_idx(recv_q[IDX_W-1:0]), .wr_data(mem_rsp_data),
    .rd_idx(off_idx), .rd_data(rd_data), .valid_vec(valid_vec)
  );

  // lookup
  logic [ADDR_W-1:0] off;
  logic              in_range;
  logic              hit;
  logic              wait_fill;
  logic              look;
  logic              miss_start;

  always_comb begin
    off        = pend_addr_q - base_q;
    in_range   = off < ADDR_W'(LINE_DW);
    off_idx    = off[IDX_W-1:0];
    hit        = in_range && valid_vec[off_idx];
    wait_fill  = in_range && fill_on_q && !hit;
    look       = (est_q == ES_LOOK);
    miss_start = look && pf_en && !hit && !wait_fill && !flush;
    kill       = flush || miss_start || !pf_en;
  end

  // memory request side
  logic fill_req, byp_req, fill_hs, byp_hs, beat, last_beat;
  logic             bursting_d;
  logic [LEN_W-1:0] beats_d;

  always_comb begin
    fill_req = fill_on_q && pf_en && !bursting_q && (issued_q < LINE_LEN)
               && (est_q != ES_BYP_REQ) && (est_q != ES_BYP_WAIT);
    byp_req  = (est_q == ES_BYP_REQ) && !bursting_q;
    mem_req_valid = fill_req || byp_req;
    mem_req_addr  = byp_req ? pend_addr_q : base_q + ADDR_W'(issued_q);
    mem_req_len   = byp_req ? ONE_LEN : fill_bs_q;
    mem_req_cmd   = RD_PLAIN;
    fill_hs   = fill_req && mem_req_ready;
    byp_hs    = byp_req && mem_req_ready;
    beat      = mem_rsp_valid && bursting_q;
    last_beat = beat && (beats_q == ONE_LEN);
    wr_en     = beat && !discard_q;

    bursting_d = bursting_q;
    beats_d    = beats_q;
    if (fill_hs) begin
      bursting_d = 1'b1;
      beats_d    = fill_bs_q;
    end else if (beat) begin
      beats_d = beats_q - ONE_LEN;
      if (last_beat) bursting_d = 1'b0;
    end
  end

  // fill controller
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      fill_on_q  <= 1'b0;
      issued_q   <= '0;
      recv_q     <= '0;
      fill_bs_q  <= ONE_LEN;
      bursting_q <= 1'b0;
      beats_q    <= '0;
      discard_q  <= 1'b0;
    end else begin
      bursting_q <= bursting_d;
      beats_q    <= beats_d;
      if (fill_hs) issued_q <= issued_q + fill_bs_q;
      if (wr_en) recv_q <= recv_q + ONE_LEN;
      if (last_beat) discard_q <= 1'b0;
      if (kill) begin
        fill_on_q <= miss_start;
        discard_q <= bursting_d;
        if (miss_start) begin
          base_q    <= pend_addr_q;
          issued_q  <= '0;
          recv_q    <= '0;
          fill_bs_q <= burst_len;
        end
      end
    end
  end

  // engine-side sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      est_q       <= ES_IDLE;
      pend_addr_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (est_q)
        ES_IDLE: if (eng_req_valid) begin
          pend_addr_q <= eng_req_addr;
          est_q       <= ES_LOOK;
        end
        ES_LOOK: begin
          if (!pf_en) est_q <= ES_BYP_REQ;
          else if (hit) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= rd_data;
            est_q       <= ES_IDLE;
          end
        end
        ES_BYP_REQ: if (byp_hs) est_q <= ES_BYP_WAIT;
        ES_BYP_WAIT: if (mem_rsp_valid && !bursting_q) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= mem_rsp_data;
          est_q       <= ES_IDLE;
        end
        default: est_q <= ES_IDLE;
      endcase
    end
  end

  assign eng_req_ready = (est_q == ES_IDLE);
  assign eng_rsp_valid = rsp_valid_q;
  assign eng_rsp_data  = rsp_data_q;
endmodule

// File: rtl/pfb_checks.sv
module pfb_checks #(
  parameter int LINE_DW   = 8,
  parameter int LEN_W     = 4,
  parameter int MIN_BURST = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               op_valid,
  input logic [1:0]         op_kind,
  input logic               op_noflush,
  input logic [LINE_DW-1:0] valid_vec,
  input logic               pf_en,
  input logic               mem_req_valid,
  input logic [LEN_W-1:0]   mem_req_len,
  input logic               bursting_q,
  input logic               eng_req_valid,
  input logic               eng_req_ready,
  input logic               eng_rsp_valid
);
  AST_MOVE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_kind == 2'd1 && !op_noflush |=> valid_vec == '0); // R8
  AST_STORE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_kind == 2'd2 |=> valid_vec == '0); // R10
  AST_BYPASS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !pf_en |-> mem_req_len == LEN_W'(1)); // R2
  AST_BURST_FLOOR: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_len != LEN_W'(1) |-> mem_req_len >= LEN_W'(MIN_BURST) && $countones(mem_req_len) == 1); // R4
  AST_ONE_BURST: assert property (@(posedge clk) disable iff (rst)
    bursting_q |-> !mem_req_valid); // R5
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    eng_req_valid && eng_req_ready |=> !eng_req_ready); // R6
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    eng_rsp_valid |=> !eng_rsp_valid); // R6
endmodule

bind code_prefetch pfb_checks #(
  .LINE_DW(LINE_DW), .LEN_W(LEN_W), .MIN_BURST(MIN_BURST)
) u_checks (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
  .op_noflush(op_noflush), .valid_vec(valid_vec), .pf_en(pf_en),
  .mem_req_valid(mem_req_valid), .mem_req_len(mem_req_len),
  .bursting_q(bursting_q), .eng_req_valid(eng_req_valid),
  .eng_req_ready(eng_req_ready), .eng_rsp_valid(eng_rsp_valid)
);

// File: tb/code_prefetch_bench.sv
module code_prefetch_bench;
  localparam int LEN_W = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic [4:0]  cfg_max_burst = 5'd8;
  logic        eng_req_valid = 1'b0;
  logic        eng_req_ready;
  logic [31:0] eng_req_addr = '0;
  logic        eng_rsp_valid;
  logic [31:0] eng_rsp_data;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic        op_noflush = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [LEN_W-1:0] mem_req_len;
  logic [1:0]  mem_req_cmd;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int total = 0;
  int bad = 0;
  int gen = 0;
  int req_cnt = 0;
  int cmd_bad = 0;
  int first_len = 0;
  logic [31:0] first_addr = '0;

  always #5 clk = ~clk;

  code_prefetch u_code_prefetch (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_max_burst(cfg_max_burst),
    .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
    .eng_req_addr(eng_req_addr), .eng_rsp_valid(eng_rsp_valid),
    .eng_rsp_data(eng_rsp_data), .op_valid(op_valid), .op_kind(op_kind),
    .op_noflush(op_noflush), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_len(mem_req_len), .mem_req_cmd(mem_req_cmd),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] word(input int g, input logic [31:0] a);
    return {8'(g) ^ 8'h5A, a[23:0]};
  endfunction

  // memory model: accepts one request, returns its beats after two idle cycles
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid && !rst) begin
        logic [31:0] a;
        int n;
        int g;
        a = mem_req_addr;
        n = int'(mem_req_len);
        g = gen;
        if (req_cnt == 0) begin
          first_len  = n;
          first_addr = a;
        end
        req_cnt++;
        if (mem_req_cmd != 2'd0) cmd_bad++;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = word(g, a + 32'(i));
          @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_counts();
    req_cnt = 0;
    first_len = 0;
    first_addr = '0;
  endtask

  task automatic fetch(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    eng_req_valid = 1'b1;
    eng_req_addr  = a;
    @(negedge clk);
    eng_req_valid = 1'b0;
    d = 32'hDEAD_BEEF;
    for (int i = 0; i < 400; i++) begin
      if (eng_rsp_valid) begin
        d = eng_rsp_data;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic op_pulse(input logic [1:0] kind, input logic nf);
    @(negedge clk);
    op_valid = 1'b1;
    op_kind = kind;
    op_noflush = nf;
    @(negedge clk);
    op_valid = 1'b0;
    op_noflush = 1'b0;
  endtask

  // enable, max burst, address, expected request count, expected first length
  localparam int VT [7][5] = '{
    '{0,  8, 'h100, 1, 1},
    '{1,  2, 'h110, 1, 1},
    '{1,  3, 'h120, 1, 1},
    '{1,  4, 'h130, 2, 4},
    '{1,  6, 'h140, 2, 4},
    '{1,  8, 'h150, 1, 8},
    '{1, 16, 'h160, 1, 8}
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready", 32'(eng_req_ready), 32'd1);
    check("R1 rsp_valid", 32'(eng_rsp_valid), 32'd0);
    check("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);

    // table-driven configuration sweep
    for (int v = 0; v < 7; v++) begin
      string tag;
      tag = (VT[v][0] == 0) ? "R2" : (VT[v][1] < 4) ? "R3" : "R4";
      op_pulse(2'd2, 1'b0);
      settle(40);
      cfg_enable    = VT[v][0][0];
      cfg_max_burst = 5'(VT[v][1]);
      settle(2);
      clr_counts();
      fetch(32'(VT[v][2]), d);
      settle(40);
      check({tag, " data"}, d, word(gen, 32'(VT[v][2])));
      check({tag, " req count"}, 32'(req_cnt), 32'(VT[v][3]));
      check({tag, " first len"}, 32'(first_len), 32'(VT[v][4]));
      check({tag, " first addr R5"}, first_addr, 32'(VT[v][2]));
    end

    // directed: miss, hits, out-of-range, flush events
    cfg_enable = 1'b1;
    cfg_max_burst = 5'd8;
    op_pulse(2'd2, 1'b0);
    settle(40);
    clr_counts();
    fetch(32'h200, d);
    settle(40);
    check("R5 miss data", d, word(gen, 32'h200));
    check("R5 miss reqs", 32'(req_cnt), 32'd1);

    clr_counts();
    fetch(32'h205, d);
    check("R6 hit data 205", d, word(gen, 32'h205));
    fetch(32'h207, d);
    check("R6 hit data 207", d, word(gen, 32'h207));
    settle(10);
    check("R6 hit reqs", 32'(req_cnt), 32'd0);

    clr_counts();
    fetch(32'h208, d);
    settle(40);
    check("R12 data", d, word(gen, 32'h208));
    check("R12 reqs", 32'(req_cnt), 32'd1);
    check("R12 addr", first_addr, 32'h208);

    clr_counts();
    op_pulse(2'd1, 1'b1);
    op_pulse(2'd0, 1'b0);
    fetch(32'h209, d);
    settle(10);
    check("R9 data", d, word(gen, 32'h209));
    check("R9 reqs", 32'(req_cnt), 32'd0);

    clr_counts();
    op_pulse(2'd1, 1'b0);
    gen++;
    fetch(32'h20A, d);
    settle(40);
    check("R8 data", d, word(gen, 32'h20A));
    check("R8 reqs", 32'(req_cnt), 32'd1);

    clr_counts();
    op_pulse(2'd2, 1'b0);
    gen++;
    fetch(32'h20B, d);
    settle(40);
    check("R10 data", d, word(gen, 32'h20B));
    check("R10 reqs", 32'(req_cnt), 32'd1);

    // flush while the first burst of a window is in flight
    cfg_max_burst = 5'd4;
    op_pulse(2'd2, 1'b0);
    settle(40);
    clr_counts();
    fork
      fetch(32'h300, d);
      begin
        wait (req_cnt == 1);
        @(negedge clk);
        op_valid = 1'b1;
        op_kind = 2'd2;
        gen++;
        @(negedge clk);
        op_valid = 1'b0;
      end
    join
    settle(40);
    check("R11 data after flush", d, word(gen, 32'h300));
    clr_counts();
    fetch(32'h303, d);
    check("R11 no stale beat", d, word(gen, 32'h303));

    check("R7 command codes", 32'(cmd_bad), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule